// File: doc/BRIEF.md
# Timer Output Fault Disable Gate

This block sits between a timer engine and its output pads and forces a chosen subset of timer outputs to high impedance while a fault is present. The fault comes from one of two places, picked by a 2-bit select input. One is a general-purpose pin level taken after the input buffer, so the chip can raise the fault by driving that pin itself. The other is a phase-error flag from a quadrature decoder.

The phase-error flag is active high. It is inverted and then passed through a two-flop synchronizer into the timer clock domain, which gives an active-low disable. A 32-bit mask register has one bit per timer channel and is loaded through a simple write port. While the disable is low, every pin whose mask bit is 1 has its output enable dropped. The other pins keep driving. Timer data passes to the pads unchanged. Output enable and data are both registered, so they stay aligned cycle for cycle. Nothing is latched: when the fault clears, the pins drive again.

Top module: `tmr_fault_gate`

## Requirements
- R1: With the pin source selected, a low `pin_fault_n` sampled at a clock edge clears `pin_oe[i]` at that edge for every i whose mask bit is 1.
- R2: A pin whose mask bit is 0 always has `pin_oe[i]` = 1, whatever the fault state.
- R3: With the phase source selected, `phase_err` is inverted and passes through two synchronizer flops. A high level sampled at edge k disables the masked pins at edge k+2, and not earlier.
- R4: `src_sel` = 2'b01 selects the phase-error source. Codes 2'b00, 2'b10 and 2'b11 select the pin source. The source that is not selected has no effect on `pin_oe`.
- R5: When `wr_en` is high at an edge, the mask register takes `wr_data` (bit i belongs to channel i). The new mask governs `pin_oe` from the following edge on.
- R6: The disable does not stick. Once the selected disable reads high, `pin_oe` returns to all ones at the next edge at which the output enable register samples it.
- R7: `pin_out` equals the `tmr_out` value sampled at the previous edge, whether or not a fault is present.
- R8: During synchronous reset, the mask clears to 0, `pin_oe` goes to all ones, `pin_out` goes to 0, and the synchronizer holds the no-fault level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Fault source select (01 = phase error, others = pin) |
| pin_fault_n | input | 1 | General-purpose pin level, low means fault |
| phase_err | input | 1 | Quadrature phase-error flag, high means fault |
| wr_en | input | 1 | Mask register write strobe |
| wr_data | input | 32 | Mask value, bit i = channel i |
| tmr_out | input | 32 | Output data from the timer engine |
| pin_out | output | 32 | Registered data to the pads |
| pin_oe | output | 32 | Registered output enables, 1 = drive |

## Verification
The bench checks the latency difference between the two sources: the pin acts after one edge, and the phase error only two edges later. A synchronizer that was one flop short, or that skipped the inversion, would disable the pins early or during the wrong polarity. The bench drives each unselected source into a fault while the other source is selected, and tries every select code. A wrong decode would let the idle source disable pins. It also rewrites the mask while a fault is active and releases the fault, to catch a design that latches the disable or applies a new mask a cycle late. Fixed-seed random stimulus covers the mixed cases against a cycle model.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  typedef enum logic [1:0] {
    SRC_PIN   = 2'b00,
    SRC_PHASE = 2'b01,
    SRC_RSV2  = 2'b10,
    SRC_RSV3  = 2'b11
  } src_sel_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/tfg_sync.sv
module tfg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tfg_src_mux.sv
module tfg_src_mux
  import tfg_pkg::*;
(
  input  logic [SEL_W-1:0] src_sel,
  input  logic             pin_level_n,
  input  logic             phase_sync_n,
  output logic             disable_n
);
  always_comb begin
    unique case (src_sel)
      SRC_PHASE: disable_n = phase_sync_n;
      default:   disable_n = pin_level_n;
    endcase
  end
endmodule

// File: rtl/tfg_mask_reg.sv
module tfg_mask_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/tfg_pin_gate.sv
module tfg_pin_gate #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disable_n,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] oe_q
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) begin
          oe_q[i]   <= 1'b1;
          data_q[i] <= 1'b0;
        end else begin
          oe_q[i]   <= disable_n | ~mask[i];
          data_q[i] <= data_in[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_fault_gate.sv
module tmr_fault_gate
  import tfg_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic                pin_fault_n,
  input  logic                phase_err,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [NUM_PINS-1:0] tmr_out,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic                phase_sync_n;
  logic                disable_n;
  logic [NUM_PINS-1:0] mask_q;

  // Phase error is active high: invert ahead of the synchronizer so the
  // chain carries the active-low level and resets to "no fault".
  tfg_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (~phase_err),
    .q  (phase_sync_n)
  );

  tfg_src_mux u_mux (
    .src_sel     (src_sel),
    .pin_level_n (pin_fault_n),
    .phase_sync_n(phase_sync_n),
    .disable_n   (disable_n)
  );

  tfg_mask_reg #(
    .WIDTH(NUM_PINS)
  ) u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .mask_q (mask_q)
  );

  tfg_pin_gate #(
    .WIDTH(NUM_PINS)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .disable_n(disable_n),
    .mask     (mask_q),
    .data_in  (tmr_out),
    .data_q   (pin_out),
    .oe_q     (pin_oe)
  );
endmodule

// File: rtl/tfg_checker.sv
module tfg_checker
  import tfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [SEL_W-1:0]    src_sel,
  input logic                pin_fault_n,
  input logic                phase_err,
  input logic                wr_en,
  input logic [NUM_PINS-1:0] wr_data,
  input logic [NUM_PINS-1:0] tmr_out,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] mask_q
);
  logic [1:0] err_run;

  always_ff @(posedge clk) begin
    if (rst) err_run <= 2'd0;
    else if (src_sel == SRC_PHASE && phase_err)
      err_run <= (err_run == 2'd3) ? 2'd3 : err_run + 2'd1;
    else err_run <= 2'd0;
  end

  AST_PIN_FAULT_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (src_sel != SRC_PHASE && !pin_fault_n) |=> ((pin_oe & $past(mask_q)) == '0)); // R1

  AST_UNMASKED_DRIVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe | $past(mask_q)) == '1)); // R2

  AST_PHASE_SYNC_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (err_run == 2'd3 && $stable(mask_q)) |-> ((pin_oe & mask_q) == '0)); // R3

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mask_q == $past(wr_data))); // R5

  AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (src_sel != SRC_PHASE && pin_fault_n) |=> (pin_oe == '1)); // R6

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_out == $past(tmr_out))); // R7

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && pin_oe == '1 && pin_out == '0)); // R8
endmodule

bind tmr_fault_gate tfg_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_sel    (src_sel),
  .pin_fault_n(pin_fault_n),
  .phase_err  (phase_err),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .tmr_out    (tmr_out),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .mask_q     (mask_q)
);

// File: tb/tmr_fault_gate_test.sv
`timescale 1ns/1ps
module tmr_fault_gate_test;
  localparam int  N      = 32;
  localparam time CLK_P  = 20ns;
  localparam int  WD_CYC = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   src_sel;
  logic         pin_fault_n;
  logic         phase_err;
  logic         wr_en;
  logic [N-1:0] wr_data;
  logic [N-1:0] tmr_out;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  string oe_tag = "R8";
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tmr_fault_gate uut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .pin_fault_n(pin_fault_n),
    .phase_err(phase_err), .wr_en(wr_en), .wr_data(wr_data),
    .tmr_out(tmr_out), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Cycle model built from the requirements.
  logic [N-1:0] m_mask, m_oe, m_out;
  logic         m_e1, m_e2;

  function automatic logic [N-1:0] exp_oe(logic [1:0] sel, logic pin_n,
                                          logic err_late, logic [N-1:0] mask);
    logic fault;
    fault = (sel == 2'b01) ? err_late : ~pin_n;
    return fault ? ~mask : '1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask <= '0; m_oe <= '1; m_out <= '0; m_e1 <= 1'b0; m_e2 <= 1'b0;
    end else begin
      m_oe   <= exp_oe(src_sel, pin_fault_n, m_e2, m_mask);
      m_out  <= tmr_out;
      m_mask <= wr_en ? wr_data : m_mask;
      m_e2   <= m_e1;
      m_e1   <= phase_err;
    end
  end

  task automatic check(string req, string what, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Advance one edge, then compare at the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(oe_tag, "pin_oe", pin_oe, m_oe);
    check("R7", "pin_out", pin_out, m_out);
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    rst = 1'b1; src_sel = 2'b00; pin_fault_n = 1'b1; phase_err = 1'b1;
    wr_en = 1'b0; wr_data = '0; tmr_out = 32'hA5A5_5A5A;
    // R8: reset state, even with a phase error present
    repeat (3) step();
    check("R8", "reset oe", pin_oe, '1);
    check("R8", "reset out", pin_out, '0);
    rst = 1'b0; phase_err = 1'b0;

    // R5: load a mask
    oe_tag = "R5";
    wr_en = 1'b1; wr_data = 32'h0000_F00F; step();
    wr_en = 1'b0; step();
    check("R5", "mask loaded, no fault", pin_oe, '1);

    // R1 / R2: pin fault
    oe_tag = "R1";
    pin_fault_n = 1'b0; step();
    check("R1", "pin fault", pin_oe, ~32'h0000_F00F);
    oe_tag = "R2";
    tmr_out = 32'h1234_5678; step();
    check("R2", "unmasked still drive", pin_oe & ~32'h0000_F00F, ~32'h0000_F00F);
    check("R7", "data during fault", pin_out, 32'h1234_5678);

    // R5: new mask while faulted takes effect one edge after the write
    oe_tag = "R5";
    wr_en = 1'b1; wr_data = 32'h8000_0001; step();
    check("R5", "write edge uses old mask", pin_oe, ~32'h0000_F00F);
    wr_en = 1'b0; step();
    check("R5", "new mask applied", pin_oe, ~32'h8000_0001);

    // R6: release
    oe_tag = "R6";
    pin_fault_n = 1'b1; step();
    check("R6", "pin release", pin_oe, '1);

    // R4: phase source selected, pin fault ignored
    oe_tag = "R4";
    src_sel = 2'b01; pin_fault_n = 1'b0; step(); step();
    check("R4", "pin ignored under phase select", pin_oe, '1);

    // R3: two-flop latency
    oe_tag = "R3";
    phase_err = 1'b1; step();
    check("R3", "err edge 1", pin_oe, '1);
    step();
    check("R3", "err edge 2", pin_oe, '1);
    step();
    check("R3", "err edge 3", pin_oe, ~32'h8000_0001);
    oe_tag = "R6";
    phase_err = 1'b0; step();
    check("R6", "phase hold 1", pin_oe, ~32'h8000_0001);
    step();
    check("R6", "phase hold 2", pin_oe, ~32'h8000_0001);
    step();
    check("R6", "phase release", pin_oe, '1);

    // R4: reserved codes use the pin; phase error ignored under pin select
    oe_tag = "R4";
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      src_sel = 2'(c); pin_fault_n = 1'b1; phase_err = 1'b1;
      step(); step(); step();
      check("R4", "phase ignored under pin select", pin_oe, '1);
      pin_fault_n = 1'b0; step();
      check("R4", "pin code disables", pin_oe, ~32'h8000_0001);
    end
    phase_err = 1'b0; pin_fault_n = 1'b1; src_sel = 2'b00; step(); step(); step();

    // Random mix against the model
    for (int k = 0; k < 3000; k++) begin
      src_sel     = 2'($urandom_range(0, 3));
      pin_fault_n = ($urandom_range(0, 3) != 0);
      phase_err   = ($urandom_range(0, 2) == 0);
      wr_en       = ($urandom_range(0, 7) == 0);
      wr_data     = $urandom();
      tmr_out     = $urandom();
      oe_tag      = (src_sel == 2'b01) ? "R3" : "R1";
      step();
    end
    wr_en = 1'b0;

    // R8: reset again mid-fault
    oe_tag = "R8";
    src_sel = 2'b00; pin_fault_n = 1'b0; rst = 1'b1; step();
    check("R8", "second reset oe", pin_oe, '1);
    check("R8", "second reset out", pin_out, '0);
    rst = 1'b0; step();
    check("R8", "mask cleared by reset", pin_oe, '1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule